// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps the sixteen most recently installed virtual-to-physical page mappings and translates a CPU virtual address in the same cycle it is presented. The upper twenty bits of the virtual address, the virtual page number, are compared against every stored tag at once. When a valid tag matches, the block drives a physical address built from that entry's physical page number and the untouched page offset. When nothing matches, the miss flag rises combinationally in that same cycle, so the exception logic can start on the next edge. The page number that missed is captured for the handler.

Each stored mapping also carries two access bits supplied at install time, plus two usage bits that the hardware keeps up to date. A referenced bit is set by any hit. A modified bit is set by a hit whose write flag is high. A page-table walker or a software handler installs mappings through the refill port. It either names a slot directly or lets the block choose one from a free-running pseudorandom generator. A flush input drops every mapping in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `paddr_o` equals the matching entry's 18-bit physical page number in bits 29..12 with `vaddr_i[11:0]` in bits 11..0, in the same cycle as the request; with no hit `paddr_o` is zero.
- R2: With `req_i` high, exactly one of `hit_o`/`miss_o` is high in the same cycle: `hit_o` when a valid entry's tag equals `vaddr_i[31:12]`, otherwise `miss_o`; with `req_i` low both are low.
- R3: A hit sets the matched entry's referenced bit; `ref_o` shows the stored bit as it was before that hit, so a second hit on the same entry reports 1.
- R4: A hit with `wr_i` high sets the matched entry's modified bit, reported on `dirty_o` by later hits; a hit with `wr_i` low leaves it unchanged.
- R5: A refill with `fill_rand_i` low writes slot `fill_idx_i` with the given page numbers and access bits, valid set and both usage bits cleared; `hit_idx_o` reports the matching slot number and `acc_o` its access bits.
- R6: A refill with `fill_rand_i` high writes the slot held in a 4-bit generator that loads 4'b0001 at reset and on every clock becomes {q[2:0], q[3]^q[2]}; it is never zero, so slot 0 is never picked by a random refill.
- R7: A refill whose virtual page number matches a valid entry overwrites that entry, whatever slot the refill named, so no two valid entries ever share a tag.
- R8: `flush_i` clears every valid bit at the next edge; a refill in the same cycle is dropped.
- R9: A cycle with `miss_o` high loads `vaddr_i[31:12]` into `bad_vpn_o` at the next edge; otherwise `bad_vpn_o` holds.
- R10: A lookup and a refill in the same cycle: the lookup sees the contents before the refill, and if both touch the same slot the refilled entry keeps clear usage bits.
- R11: After reset, no entry is valid and `bad_vpn_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request |
| wr_i | input | 1 | Request is a store |
| vaddr_i | input | 32 | Virtual address |
| paddr_o | output | 30 | Translated physical address |
| hit_o | output | 1 | Mapping found |
| miss_o | output | 1 | No mapping found |
| hit_idx_o | output | 4 | Slot that matched |
| acc_o | output | 2 | Access bits of the matched slot |
| ref_o | output | 1 | Stored referenced bit of the matched slot |
| dirty_o | output | 1 | Stored modified bit of the matched slot |
| bad_vpn_o | output | 20 | Last virtual page number that missed |
| fill_en_i | input | 1 | Install a mapping |
| fill_rand_i | input | 1 | Use the pseudorandom slot instead of fill_idx_i |
| fill_idx_i | input | 4 | Explicit slot for the install |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_ppn_i | input | 18 | Physical page number to install |
| fill_acc_i | input | 2 | Access bits to install |
| flush_i | input | 1 | Invalidate all mappings |

## Verification
Two cases are provoked in the same cycle. In the first, a write hit updates the usage bits of the same slot that a refill is overwriting. In the second, a flush arrives together with a refill. Each is set up once as a directed cycle and then again many times in a random mix of requests, refills and flushes over a small pool of page numbers. The result is judged by the following lookups: the newly installed entry must report clear referenced and modified bits, and after a flush the page that was refilled at the same time must miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 30;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int ACC_W   = 2;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [ACC_W-1:0] acc;
        logic             refd;
        logic             dirty;
    } xlat_ent_t;

    typedef struct packed {
        xlat_ent_t [ENTRIES-1:0] ent;
        logic [VPN_W-1:0]        bad;
    } xlat_state_t;
endpackage

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;
    logic         fb;

    generate
        if (W == 3) begin : g_w3
            assign fb = q_q[2] ^ q_q[1];
        end else if (W == 5) begin : g_w5
            assign fb = q_q[4] ^ q_q[2];
        end else begin : g_wx
            assign fb = q_q[W-1] ^ q_q[W-2];
        end
    endgenerate

    always_comb begin
        q_d = {q_q[W-2:0], fb};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= {{(W-1){1'b0}}, 1'b1};
        else         q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 16,
    parameter int KEY_W = 20,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][KEY_W-1:0] tag_i,
    input  logic [KEY_W-1:0]        key_i,
    output logic [N-1:0]            hit_vec_o,
    output logic                    any_o,
    output logic [IW-1:0]           idx_o
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec_o[i] = valid_i[i] && (tag_i[i] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec_o[i]) idx_o = idx_o | IW'(i);
        end
    end

    assign any_o = |hit_vec_o;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic [VA_W-1:0]  vaddr_i,
    output logic [PA_W-1:0]  paddr_o,
    output logic             hit_o,
    output logic             miss_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             ref_o,
    output logic             dirty_o,
    output logic [VPN_W-1:0] bad_vpn_o,
    input  logic             fill_en_i,
    input  logic             fill_rand_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic [ACC_W-1:0] fill_acc_i,
    input  logic             flush_i
);
    xlat_state_t st_d, st_q;

    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [VPN_W-1:0]              look_vpn;
    logic [ENTRIES-1:0]            look_vec, dup_vec;
    logic                          look_any, dup_any;
    logic [IDX_W-1:0]              look_idx, dup_idx;
    logic [IDX_W-1:0]              rnd_slot, fill_slot;
    logic                          look_hit;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_valid[i] = st_q.ent[i].valid;
            ent_vpn[i]   = st_q.ent[i].vpn;
        end
    end

    assign look_vpn = vaddr_i[VA_W-1:OFF_W];

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_look (
        .valid_i  (ent_valid),
        .tag_i    (ent_vpn),
        .key_i    (look_vpn),
        .hit_vec_o(look_vec),
        .any_o    (look_any),
        .idx_o    (look_idx)
    );

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_dup (
        .valid_i  (ent_valid),
        .tag_i    (ent_vpn),
        .key_i    (fill_vpn_i),
        .hit_vec_o(dup_vec),
        .any_o    (dup_any),
        .idx_o    (dup_idx)
    );

    xlat_lfsr #(.W(IDX_W)) u_rnd (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .q_o   (rnd_slot)
    );

    assign look_hit  = req_i && look_any;
    assign fill_slot = dup_any ? dup_idx : (fill_rand_i ? rnd_slot : fill_idx_i);

    // lookup outputs
    always_comb begin
        hit_o     = look_hit;
        miss_o    = req_i && !look_any;
        hit_idx_o = look_hit ? look_idx : '0;
        paddr_o   = '0;
        acc_o     = '0;
        ref_o     = 1'b0;
        dirty_o   = 1'b0;
        if (look_hit) begin
            paddr_o = {st_q.ent[look_idx].ppn, vaddr_i[OFF_W-1:0]};
            acc_o   = st_q.ent[look_idx].acc;
            ref_o   = st_q.ent[look_idx].refd;
            dirty_o = st_q.ent[look_idx].dirty;
        end
        bad_vpn_o = st_q.bad;
    end

    // next state: usage update, then refill, then flush (later wins)
    always_comb begin
        st_d = st_q;
        if (look_hit) begin
            st_d.ent[look_idx].refd = 1'b1;
            if (wr_i) st_d.ent[look_idx].dirty = 1'b1;
        end
        if (miss_o) st_d.bad = look_vpn;
        if (fill_en_i) begin
            st_d.ent[fill_slot] = '{valid: 1'b1, vpn: fill_vpn_i, ppn: fill_ppn_i,
                                    acc: fill_acc_i, refd: 1'b0, dirty: 1'b0};
        end
        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_i,
    input logic [VA_W-1:0]    vaddr_i,
    input logic [PA_W-1:0]    paddr_o,
    input logic               hit_o,
    input logic               miss_o,
    input logic [VPN_W-1:0]   bad_vpn_o,
    input logic               flush_i,
    input logic [ENTRIES-1:0] look_vec,
    input logic [IDX_W-1:0]   rnd_slot
);
    // R2
    hit_miss_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_o || miss_o) == req_i);
    // R2
    hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && miss_o));
    // R1
    offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> paddr_o[OFF_W-1:0] == vaddr_i[OFF_W-1:0]);
    // R7
    single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(look_vec));
    // R6
    rnd_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_slot != '0);
    // R9
    bad_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_o |=> bad_vpn_o == $past(vaddr_i[VA_W-1:OFF_W]));
    // R9
    bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miss_o |=> $stable(bad_vpn_o));
    // R8
    flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !hit_o);
endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .vaddr_i  (vaddr_i),
    .paddr_o  (paddr_o),
    .hit_o    (hit_o),
    .miss_o   (miss_o),
    .bad_vpn_o(bad_vpn_o),
    .flush_i  (flush_i),
    .look_vec (look_vec),
    .rnd_slot (rnd_slot)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
    logic        clk_r = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_r, wr_r, fill_r, rnd_r, flush_r;
    logic [31:0] vaddr_r;
    logic [3:0]  fidx_r;
    logic [19:0] fvpn_r;
    logic [17:0] fppn_r;
    logic [1:0]  facc_r;

    logic [29:0] paddr_o;
    logic        hit_o, miss_o, ref_o, dirty_o;
    logic [3:0]  hit_idx_o;
    logic [1:0]  acc_o;
    logic [19:0] bad_vpn_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model
    logic        m_v[16];
    logic [19:0] m_vpn[16];
    logic [17:0] m_ppn[16];
    logic [1:0]  m_acc[16];
    logic        m_ref[16];
    logic        m_dirty[16];
    logic [19:0] m_bad;
    logic [3:0]  m_lfsr;

    // last sampled outputs
    logic        s_hit, s_ref, s_dirty;
    logic [3:0]  s_idx;
    logic [29:0] s_pa;

    always #2.5 clk_r = ~clk_r;

    xlat_cache dut_i (
        .clk_i(clk_r), .rst_ni(rst_n), .req_i(req_r), .wr_i(wr_r), .vaddr_i(vaddr_r),
        .paddr_o(paddr_o), .hit_o(hit_o), .miss_o(miss_o), .hit_idx_o(hit_idx_o),
        .acc_o(acc_o), .ref_o(ref_o), .dirty_o(dirty_o), .bad_vpn_o(bad_vpn_o),
        .fill_en_i(fill_r), .fill_rand_i(rnd_r), .fill_idx_i(fidx_r),
        .fill_vpn_i(fvpn_r), .fill_ppn_i(fppn_r), .fill_acc_i(facc_r), .flush_i(flush_r)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int find(logic [19:0] k);
        for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == k) return i;
        return -1;
    endfunction

    function automatic logic [3:0] lfsr_next(logic [3:0] q);
        return {q[2:0], q[3] ^ q[2]};
    endfunction

    task automatic idle();
        req_r = 0; wr_r = 0; vaddr_r = '0; fill_r = 0; rnd_r = 0; flush_r = 0;
        fidx_r = '0; fvpn_r = '0; fppn_r = '0; facc_r = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_acc[i] = '0;
            m_ref[i] = 0; m_dirty[i] = 0;
        end
        m_bad = '0; m_lfsr = 4'b0001;
    endtask

    // one clock: check combinational outputs, advance model, leave inputs idle
    task automatic step();
        int e; int d; int slot;
        logic eh, em;
        #1;
        e  = find(vaddr_r[31:12]);
        eh = req_r && (e >= 0);
        em = req_r && (e < 0);
        s_hit = hit_o; s_idx = hit_idx_o; s_ref = ref_o; s_dirty = dirty_o; s_pa = paddr_o;
        chk("R2 hit", 32'(hit_o), 32'(eh));
        chk("R2 miss", 32'(miss_o), 32'(em));
        if (eh) begin
            chk("R1 paddr", 32'(paddr_o), 32'({m_ppn[e], vaddr_r[11:0]}));
            chk("R5 idx", 32'(hit_idx_o), 32'(e));
            chk("R5 acc", 32'(acc_o), 32'(m_acc[e]));
            chk("R3 ref", 32'(ref_o), 32'(m_ref[e]));
            chk("R4 dirty", 32'(dirty_o), 32'(m_dirty[e]));
        end else begin
            chk("R1 paddr zero", 32'(paddr_o), 32'h0);
        end
        chk("R9 bad vpn", 32'(bad_vpn_o), 32'(m_bad));
        @(posedge clk_r);
        d = find(fvpn_r);
        if (eh) begin
            m_ref[e] = 1;
            if (wr_r) m_dirty[e] = 1;
        end
        if (em) m_bad = vaddr_r[31:12];
        if (fill_r) begin
            slot = (d >= 0) ? d : (rnd_r ? int'(m_lfsr) : int'(fidx_r));
            m_v[slot] = 1; m_vpn[slot] = fvpn_r; m_ppn[slot] = fppn_r;
            m_acc[slot] = facc_r; m_ref[slot] = 0; m_dirty[slot] = 0;
        end
        if (flush_r) for (int i = 0; i < 16; i++) m_v[i] = 0;
        m_lfsr = lfsr_next(m_lfsr);
        @(negedge clk_r);
        idle();
    endtask

    task automatic look(logic [31:0] va, logic w);
        req_r = 1; wr_r = w; vaddr_r = va;
        step();
    endtask

    task automatic fill(logic [19:0] vpn, logic [17:0] ppn, logic [1:0] acc,
                        logic rnd, logic [3:0] idx);
        fill_r = 1; fvpn_r = vpn; fppn_r = ppn; facc_r = acc; rnd_r = rnd; fidx_r = idx;
        step();
    endtask

    initial begin
        logic [3:0] exp_slot;
        idle();
        model_reset();
        req_r = 1; vaddr_r = 32'hDEAD_B123;
        repeat (3) @(posedge clk_r);
        @(negedge clk_r);
        #1;
        // R11: nothing valid during reset, bad page zero
        chk("R11 no hit in reset", 32'(hit_o), 32'h0);
        chk("R11 bad vpn reset", 32'(bad_vpn_o), 32'h0);
        idle();
        rst_n = 1;

        // R11 / R2 / R9: first lookup misses and captures its page
        look(32'h1234_5678, 0);
        chk("R11 miss after reset", 32'(s_hit), 32'h0);
        look(32'h0000_0000, 0);

        // R5: explicit slot refill, then hit with translation (R1)
        fill(20'h12345, 18'h2ABCD, 2'd2, 0, 4'd3);
        look(32'h1234_5678, 0);
        chk("R5 explicit slot", 32'(s_idx), 32'd3);
        chk("R1 translated", 32'(s_pa), 32'h2ABC_D678);

        // R3 / R4: usage bits
        look(32'h1234_5000, 0);
        chk("R3 ref after read hit", 32'(s_ref), 32'd1);
        chk("R4 read leaves dirty", 32'(s_dirty), 32'd0);
        look(32'h1234_5004, 1);
        look(32'h1234_5008, 0);
        chk("R4 dirty after write hit", 32'(s_dirty), 32'd1);

        // R6: pseudorandom slot follows the generator and is nonzero
        exp_slot = m_lfsr;
        fill(20'h00AAA, 18'h01111, 2'd1, 1, 4'd0);
        look(32'h00AA_A010, 0);
        chk("R6 random slot", 32'(s_idx), 32'(exp_slot));
        chk("R6 slot nonzero", 32'(s_idx != 0), 32'd1);

        // R7: duplicate page overwrites its existing slot
        fill(20'h12345, 18'h3FFFF, 2'd3, 0, 4'd7);
        look(32'h1234_5ABC, 0);
        chk("R7 same slot", 32'(s_idx), 32'd3);
        chk("R7 new frame", 32'(s_pa), 32'h3FFF_FABC);

        // R10: write hit on slot 3 and refill of slot 3 in one cycle
        req_r = 1; wr_r = 1; vaddr_r = 32'h1234_5000;
        fill_r = 1; fvpn_r = 20'h0BEEF; fppn_r = 18'h00042; facc_r = 2'd0; fidx_r = 4'd3;
        step();
        chk("R10 lookup saw old entry", 32'(s_pa), 32'h3FFF_F000);
        look(32'h0BEE_F00C, 0);
        chk("R10 refill wins ref", 32'(s_ref), 32'd0);
        chk("R10 refill wins dirty", 32'(s_dirty), 32'd0);
        look(32'h1234_5000, 0);
        chk("R10 old page gone", 32'(s_hit), 32'd0);

        // R8: flush with a refill in the same cycle
        flush_r = 1; fill_r = 1; fvpn_r = 20'h55555; fppn_r = 18'h00555; fidx_r = 4'd9;
        step();
        look(32'h0BEE_F000, 0);
        chk("R8 flushed entry misses", 32'(s_hit), 32'd0);
        look(32'h5555_5000, 0);
        chk("R8 refill dropped", 32'(s_hit), 32'd0);

        // mixed random traffic over a small page pool
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            req_r   = (r[3:0] < 4'd11);
            wr_r    = r[4];
            vaddr_r = {20'h4A000 + 20'($urandom % 24), 12'($urandom)};
            if (r[9:5] < 5'd7) begin
                fill_r = 1; rnd_r = r[10]; fidx_r = 4'($urandom);
                fvpn_r = 20'h4A000 + 20'($urandom % 24);
                fppn_r = 18'($urandom); facc_r = 2'($urandom);
            end
            flush_r = (r[17:11] == 7'd0);
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule